// File: doc/BRIEF.md
# Segment Translation and Protection Unit

This block turns a virtual address, made of a segment number in the upper bits and an offset in the lower bits, into a physical address. It looks the segment up in a small table of internal registers. Each table entry holds a physical base, a size limit and a two-bit access right. Each request says whether it is a read or a write. One cycle after the request the block returns either a valid physical address (base plus offset) or one or both fault flags: a bound fault when the offset lies past the segment's limit, and a protection fault when the access right does not allow the operation.

The table is held in several context banks. Privileged software fills any bank through a configuration port and makes one of them active when it switches processes, so a whole table is replaced in a single cycle instead of being rewritten entry by entry. The block ignores configuration writes and bank switches made while the privilege input is low.

Top module: `seg_xlate`

## Requirements
- R1: The segment number is `req_vaddr_i[15:13]` and the offset is `req_vaddr_i[12:0]`. One cycle after an accepted request, a legal access raises `rsp_ok_o` and drives `rsp_pa_o` with the entry base plus the zero-extended offset, modulo 2^32.
- R2: An offset greater than the entry's size field raises `rsp_bound_fault_o`. An offset equal to the size field is legal.
- R3: The rights codes are 2'b00 no access, 2'b01 read only, 2'b11 read and write, and 2'b10 is treated as no access. A read needs 01 or 11 and a write needs 11. Any other combination raises `rsp_prot_fault_o`.
- R4: Every access to a segment whose right is no access raises `rsp_prot_fault_o`, whatever its offset.
- R5: Any fault forces `rsp_ok_o` low. A bound fault and a protection fault may be raised in the same response.
- R6: Each request (`req_valid_i` high at a clock edge) yields, at the next edge, exactly one response cycle in which `rsp_ok_o` or at least one fault flag is high. Requests in consecutive cycles each get their own response.
- R7: A cycle with no request leaves `rsp_ok_o` and both fault flags low at the following edge.
- R8: Table writes (`cfg_we_i`) and bank switches (`cfg_switch_i`) take effect only while `priv_i` is high. Otherwise they change nothing.
- R9: `rsp_pa_o` reads zero whenever `rsp_ok_o` is low.
- R10: After reset, every entry in every bank has base 0, size 0 and right no access, bank 0 is active, and all response outputs are low.
- R11: A privileged switch makes bank `cfg_ctx_i` the active bank for requests from the next cycle on. A write to a bank that is not active does not change translations. A write is visible to a request made in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| priv_i | input | 1 | Privileged mode, enables configuration |
| cfg_we_i | input | 1 | Write one table entry |
| cfg_switch_i | input | 1 | Make bank `cfg_ctx_i` active |
| cfg_ctx_i | input | 1 | Bank addressed by a write or a switch |
| cfg_seg_i | input | 3 | Segment entry addressed by a write |
| cfg_base_i | input | 32 | Physical base to store |
| cfg_size_i | input | 13 | Highest legal offset to store |
| cfg_rights_i | input | 2 | Access right to store |
| req_valid_i | input | 1 | Translation request |
| req_write_i | input | 1 | 1 = write access, 0 = read access |
| req_vaddr_i | input | 16 | Virtual address {segment, offset} |
| rsp_ok_o | output | 1 | Translation succeeded |
| rsp_pa_o | output | 32 | Physical address, zero unless ok |
| rsp_bound_fault_o | output | 1 | Offset beyond segment size |
| rsp_prot_fault_o | output | 1 | Access right violated |

## Verification
On every cycle the assertions check that a fault and a success are never reported together, that the address bus is zero without success, that each request gets a response one cycle later and each idle cycle gets none, that a no-access entry always faults, and that the active bank moves only on a privileged switch. The exact physical address, the boundary at offset equal to size, the rights decode for reads against writes, and the isolation between banks depend on the table contents. Only the bench scenarios show these, by comparing against its own shadow of what it programmed. The same holds for user-mode writes being dropped, which the bench observes through later translations.

// File: rtl/seg_pkg.sv
package seg_pkg;
  parameter int SEG_W = 3;
  parameter int OFF_W = 13;
  parameter int PA_W  = 32;
  parameter int CTX_N = 2;

  localparam int SEG_N = 1 << SEG_W;
  localparam int VA_W  = SEG_W + OFF_W;
  localparam int CTX_W = (CTX_N > 1) ? $clog2(CTX_N) : 1;

  typedef enum logic [1:0] {
    RT_NONE = 2'b00,
    RT_RD   = 2'b01,
    RT_RSV  = 2'b10,
    RT_RW   = 2'b11
  } rights_e;

  typedef struct packed {
    logic [PA_W-1:0]  base;
    logic [OFF_W-1:0] limit;
    rights_e          rights;
  } seg_ent_t;

  // Physical address: base plus zero-extended offset, wrapping.
  function automatic logic [PA_W-1:0] f_phys(input logic [PA_W-1:0] base,
                                             input logic [OFF_W-1:0] off);
    return base + PA_W'(off);
  endfunction

  // Offset lies past the last legal byte of the segment.
  function automatic logic f_over(input logic [OFF_W-1:0] off,
                                  input logic [OFF_W-1:0] limit);
    return off > limit;
  endfunction

  // Access right permits the operation.
  function automatic logic f_allow(input rights_e rt, input logic is_wr);
    logic ok;
    unique case (rt)
      RT_RW:   ok = 1'b1;
      RT_RD:   ok = !is_wr;
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction
endpackage

// File: rtl/seg_table.sv
module seg_table
  import seg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             sw_en,
  input  logic [CTX_W-1:0] cfg_ctx,
  input  logic [SEG_W-1:0] cfg_seg,
  input  seg_ent_t         cfg_ent,
  input  logic [SEG_W-1:0] look_seg,
  output seg_ent_t         look_ent,
  output logic [CTX_W-1:0] act_ctx
);
  seg_ent_t ent_q [CTX_N][SEG_N];

  for (genvar c = 0; c < CTX_N; c++) begin : g_ctx
    for (genvar s = 0; s < SEG_N; s++) begin : g_seg
      logic hit_w;
      assign hit_w = wr_en && (cfg_ctx == CTX_W'(c)) && (cfg_seg == SEG_W'(s));
      always_ff @(posedge clk) begin
        if (!rst_n)      ent_q[c][s] <= '0;
        else if (hit_w)  ent_q[c][s] <= cfg_ent;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      act_ctx <= '0;
    else if (sw_en)  act_ctx <= cfg_ctx;
  end

  assign look_ent = ent_q[act_ctx][look_seg];
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_pkg::*;
(
  input  seg_ent_t         ent,
  input  logic [OFF_W-1:0] off,
  input  logic             is_wr,
  output logic             bound_hit,
  output logic             prot_hit,
  output logic [PA_W-1:0]  pa
);
  always_comb begin
    bound_hit = f_over(off, ent.limit);
    prot_hit  = !f_allow(ent.rights, is_wr);
    pa        = f_phys(ent.base, off);
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              priv_i,
  input  logic              cfg_we_i,
  input  logic              cfg_switch_i,
  input  logic [CTX_W-1:0]  cfg_ctx_i,
  input  logic [SEG_W-1:0]  cfg_seg_i,
  input  logic [PA_W-1:0]   cfg_base_i,
  input  logic [OFF_W-1:0]  cfg_size_i,
  input  logic [1:0]        cfg_rights_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [VA_W-1:0]   req_vaddr_i,
  output logic              rsp_ok_o,
  output logic [PA_W-1:0]   rsp_pa_o,
  output logic              rsp_bound_fault_o,
  output logic              rsp_prot_fault_o
);
  // Named internal events for the checker
  logic             tbl_wr_fire;
  logic             tbl_sw_fire;
  logic [SEG_W-1:0] va_seg;
  logic [OFF_W-1:0] va_off;
  seg_ent_t         cfg_ent;
  seg_ent_t         look_ent;
  logic [CTX_W-1:0] act_ctx;
  logic             bound_hit;
  logic             prot_hit;
  logic [PA_W-1:0]  pa_raw;
  rights_e          look_rights;

  assign tbl_wr_fire = cfg_we_i && priv_i;
  assign tbl_sw_fire = cfg_switch_i && priv_i;
  assign va_seg      = req_vaddr_i[VA_W-1:OFF_W];
  assign va_off      = req_vaddr_i[OFF_W-1:0];
  assign cfg_ent     = '{base: cfg_base_i, limit: cfg_size_i,
                         rights: rights_e'(cfg_rights_i)};
  assign look_rights = look_ent.rights;

  seg_table u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (tbl_wr_fire),
    .sw_en    (tbl_sw_fire),
    .cfg_ctx  (cfg_ctx_i),
    .cfg_seg  (cfg_seg_i),
    .cfg_ent  (cfg_ent),
    .look_seg (va_seg),
    .look_ent (look_ent),
    .act_ctx  (act_ctx)
  );

  seg_check u_check (
    .ent       (look_ent),
    .off       (va_off),
    .is_wr     (req_write_i),
    .bound_hit (bound_hit),
    .prot_hit  (prot_hit),
    .pa        (pa_raw)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_ok_o          <= 1'b0;
      rsp_pa_o          <= '0;
      rsp_bound_fault_o <= 1'b0;
      rsp_prot_fault_o  <= 1'b0;
    end else begin
      rsp_ok_o          <= req_valid_i && !bound_hit && !prot_hit;
      rsp_pa_o          <= (req_valid_i && !bound_hit && !prot_hit) ? pa_raw : '0;
      rsp_bound_fault_o <= req_valid_i && bound_hit;
      rsp_prot_fault_o  <= req_valid_i && prot_hit;
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk
  import seg_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             priv_i,
  input logic             cfg_switch_i,
  input logic             req_valid_i,
  input rights_e          look_rights,
  input logic [CTX_W-1:0] act_ctx,
  input logic             rsp_ok_o,
  input logic [PA_W-1:0]  rsp_pa_o,
  input logic             rsp_bound_fault_o,
  input logic             rsp_prot_fault_o
);
  // R5
  fault_blocks_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_bound_fault_o || rsp_prot_fault_o) |-> !rsp_ok_o);

  // R9
  pa_zero_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_ok_o |-> (rsp_pa_o == '0));

  // R6
  req_answered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i |=> (rsp_ok_o || rsp_bound_fault_o || rsp_prot_fault_o));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid_i |=> (!rsp_ok_o && !rsp_bound_fault_o && !rsp_prot_fault_o));

  // R4
  nil_faults_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && (look_rights == RT_NONE)) |=> rsp_prot_fault_o);

  // R8
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(priv_i && cfg_switch_i) |=> $stable(act_ctx));
endmodule

bind seg_xlate seg_xlate_chk u_chk (
  .clk               (clk),
  .rst_n             (rst_n),
  .priv_i            (priv_i),
  .cfg_switch_i      (cfg_switch_i),
  .req_valid_i       (req_valid_i),
  .look_rights       (look_rights),
  .act_ctx           (act_ctx),
  .rsp_ok_o          (rsp_ok_o),
  .rsp_pa_o          (rsp_pa_o),
  .rsp_bound_fault_o (rsp_bound_fault_o),
  .rsp_prot_fault_o  (rsp_prot_fault_o)
);

// File: tb/seg_xlate_bench.sv
`timescale 1ns/1ps
module seg_xlate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        priv_i = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic        cfg_switch_i = 1'b0;
  logic [0:0]  cfg_ctx_i = '0;
  logic [2:0]  cfg_seg_i = '0;
  logic [31:0] cfg_base_i = '0;
  logic [12:0] cfg_size_i = '0;
  logic [1:0]  cfg_rights_i = '0;
  logic        req_valid_i = 1'b0;
  logic        req_write_i = 1'b0;
  logic [15:0] req_vaddr_i = '0;
  logic        rsp_ok_o;
  logic [31:0] rsp_pa_o;
  logic        rsp_bound_fault_o;
  logic        rsp_prot_fault_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // Shadow of programmed bases per bank and segment
  logic [31:0] base_sh [2][8];

  always #2 clk = ~clk;

  seg_xlate u_seg_xlate (.*);

  // Vector: {write, seg[2:0], off[12:0], exp_ok, exp_bound, exp_prot}
  localparam logic [19:0] VEC [10] = '{
    {1'b0, 3'd0, 13'h0123, 3'b100},  // plain read
    {1'b1, 3'd0, 13'h0FFF, 3'b100},  // R2 offset == size legal
    {1'b0, 3'd0, 13'h1000, 3'b010},  // R2 one past size
    {1'b0, 3'd1, 13'h00FF, 3'b100},  // R3 read of read-only
    {1'b1, 3'd1, 13'h0010, 3'b001},  // R3 write of read-only
    {1'b1, 3'd1, 13'h0100, 3'b011},  // R5 both faults
    {1'b0, 3'd2, 13'h0000, 3'b001},  // R4 nil segment
    {1'b0, 3'd3, 13'h1FFF, 3'b100},  // R1 address wrap
    {1'b0, 3'd4, 13'h0000, 3'b001},  // R3 code 10 acts as nil
    {1'b0, 3'd5, 13'h0000, 3'b001}   // R10 never written
  };

  task automatic chk(input string tag, input logic ok_e, input logic bf_e,
                     input logic pf_e, input logic [31:0] pa_e);
    n_vec++;
    if (rsp_ok_o !== ok_e || rsp_bound_fault_o !== bf_e ||
        rsp_prot_fault_o !== pf_e || rsp_pa_o !== pa_e) begin
      n_bad++;
      $display("FAIL %s: ok/bf/pf/pa = %b%b%b %h, expected %b%b%b %h", tag,
               rsp_ok_o, rsp_bound_fault_o, rsp_prot_fault_o, rsp_pa_o,
               ok_e, bf_e, pf_e, pa_e);
    end
  endtask

  task automatic cfg_wr(input logic pv, input logic ctx, input logic [2:0] seg,
                        input logic [31:0] base, input logic [12:0] size,
                        input logic [1:0] rt);
    priv_i = pv; cfg_we_i = 1'b1; cfg_ctx_i = ctx; cfg_seg_i = seg;
    cfg_base_i = base; cfg_size_i = size; cfg_rights_i = rt;
    @(posedge clk); #1;
    cfg_we_i = 1'b0; priv_i = 1'b0;
    if (pv) base_sh[ctx][seg] = base;
  endtask

  task automatic cfg_sw(input logic pv, input logic ctx);
    priv_i = pv; cfg_switch_i = 1'b1; cfg_ctx_i = ctx;
    @(posedge clk); #1;
    cfg_switch_i = 1'b0; priv_i = 1'b0;
  endtask

  // Issue one request; returns after the response edge, outputs settled.
  task automatic req(input logic wr, input logic [2:0] seg, input logic [12:0] off);
    req_valid_i = 1'b1; req_write_i = wr; req_vaddr_i = {seg, off};
    @(posedge clk); #1;
    req_valid_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 2; c++)
      for (int s = 0; s < 8; s++) base_sh[c][s] = '0;
    repeat (3) @(posedge clk); #1;
    chk("R10 outputs in reset", 0, 0, 0, 32'h0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R10 outputs after reset", 0, 0, 0, 32'h0);
    req(1'b0, 3'd0, 13'h0000);
    chk("R10 entry nil after reset", 0, 0, 1, 32'h0);

    cfg_wr(1, 0, 3'd0, 32'h1000_0000, 13'h0FFF, 2'b11);
    cfg_wr(1, 0, 3'd1, 32'h2000_0000, 13'h00FF, 2'b01);
    cfg_wr(1, 0, 3'd2, 32'h3000_0000, 13'h1FFF, 2'b00);
    cfg_wr(1, 0, 3'd3, 32'hFFFF_F000, 13'h1FFF, 2'b11);
    cfg_wr(1, 0, 3'd4, 32'h4000_0000, 13'h0100, 2'b10);

    for (int i = 0; i < 10; i++) begin
      logic [19:0] v;
      logic [31:0] pa_e;
      v = VEC[i];
      req(v[19], v[18:16], v[15:3]);
      pa_e = v[2] ? (base_sh[0][v[18:16]] + {19'h0, v[15:3]}) : 32'h0;
      chk($sformatf("R1/R2/R3 vector %0d (R1 R2 R3 R4 R5 R9)", i),
          v[2], v[1], v[0], pa_e);
    end

    // R8: user-mode write and switch leave everything as it was
    cfg_wr(0, 0, 3'd0, 32'h0, 13'h0, 2'b00);
    req(1'b0, 3'd0, 13'h0010);
    chk("R8 user write ignored", 1, 0, 0, 32'h1000_0010);
    cfg_sw(0, 1'b1);
    req(1'b0, 3'd0, 13'h0010);
    chk("R8 user switch ignored", 1, 0, 0, 32'h1000_0010);

    // R11: write to inactive bank does not disturb active one
    cfg_wr(1, 1, 3'd0, 32'h5000_0000, 13'h0010, 2'b11);
    req(1'b1, 3'd0, 13'h0020);
    chk("R11 inactive bank write isolated", 1, 0, 0, 32'h1000_0020);
    cfg_sw(1, 1'b1);
    req(1'b0, 3'd0, 13'h0010);
    chk("R11 switched bank translates", 1, 0, 0, 32'h5000_0010);
    req(1'b0, 3'd0, 13'h0011);
    chk("R11 switched bank size", 0, 1, 0, 32'h0);

    // R11: a write is visible to the very next request
    cfg_wr(1, 1, 3'd1, 32'h6000_0000, 13'h00FF, 2'b11);
    req(1'b1, 3'd1, 13'h00FF);
    chk("R11 write visible next cycle", 1, 0, 0, 32'h6000_00FF);

    // R6: back-to-back requests
    req_valid_i = 1'b1; req_write_i = 1'b0; req_vaddr_i = {3'd0, 13'h0001};
    @(posedge clk); #1;
    req_write_i = 1'b1; req_vaddr_i = {3'd1, 13'h0100};
    chk("R6 first of back-to-back", 1, 0, 0, 32'h5000_0001);
    @(posedge clk); #1;
    req_valid_i = 1'b0;
    chk("R6 second of back-to-back", 0, 1, 0, 32'h0);
    @(posedge clk); #1;
    chk("R7 idle after requests", 0, 0, 0, 32'h0);

    // R10: reset clears table and returns to bank 0
    rst_n = 1'b0;
    @(posedge clk); #1;
    chk("R10 outputs on second reset", 0, 0, 0, 32'h0);
    rst_n = 1'b1;
    req(1'b0, 3'd0, 13'h0000);
    chk("R10 table cleared by reset", 0, 0, 1, 32'h0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule